// File: doc/BRIEF.md
# External Pin Interrupt Detector

This block watches one non-maskable pin and a parameterised set of maskable external interrupt pins (sixteen by default). Each pin passes through a multi-stage synchroniser. A per-channel detector then applies the sense mode that software has chosen for that channel. For each channel it keeps one status flag and drives one active-high level request toward a parent interrupt controller. The request stays high for as long as the flag is set.

Software reaches the block through a plain 32-bit register port. Each channel has a mode field in a sense register, the status flags can be read back, and a separate write-one-to-clear address clears them. The non-maskable channel detects edges only. The maskable channels also offer a level-low mode, in which the flag tracks the pin and is never latched.

Top module: `ext_pin_irq_detect`

## Requirements
- R1: After reset every sense field is 0, every status flag is 0, and with the pins held at their idle-high level all request outputs are low.
- R2: The register offsets are: non-maskable status 0x00, non-maskable clear 0x04, non-maskable sense 0x08, maskable status 0x10, maskable clear 0x14, maskable sense 0x18. Reads of the two clear offsets, and of any other unmapped offset, return 0.
- R3: Channel n owns the 2-bit field at bits [2n+1:2n] of the maskable sense register. The codes are 0 = level low, 1 = falling edge, 2 = rising edge, 3 = both edges. The register reads back as written.
- R4: In an edge mode, a matching transition on a channel pin sets that channel's status flag. A pin change set up before clock edge k appears on the flag after edge k+2, because the pin crosses two synchroniser flops and one detector flop. Transitions that do not match the mode leave the flag alone.
- R5: In an edge mode, writing 1 to bit n at offset 0x14 clears flag n. Writing 0 to a bit leaves that flag unchanged.
- R6: In level-low mode, the flag of channel n is 1 while the synchronised pin is low and 0 while it is high. It follows the pin with the same latency as R4, and clear writes have no effect on it.
- R7: When a detected edge and a clear write for the same channel meet in one cycle, the flag ends up set.
- R8: Bit 0 of the non-maskable sense register selects falling edge (0) or rising edge (1). Writing 1 to bit 0 of offset 0x04 clears the non-maskable flag, and writing 0 there has no effect.
- R9: Each request output equals its status flag, and status bit n at offset 0x10 equals irq_req[n].
- R10: Rewriting a sense field while the pin is steady does not set the flag in any edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pins | input | NUM_CH | Maskable interrupt pins, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| nmi_req | output | 1 | Level-high request for the non-maskable channel |
| irq_req | output | NUM_CH | Level-high requests, one per maskable channel |

## Verification
The bench builds the block with its defaults: NUM_CH = 16, SYNC_STAGES = 2 and ADDR_W = 8. With these values every channel can be swept through all four sense codes, using falling and rising stimulus in turn. Expected flags come from a small table of mode against transition. The two-stage synchroniser fixes the latency at three edges, so the bench can place a clear write in exactly the same cycle as a detected edge and check that the set wins. The 8-bit address space is small enough to step through every word offset when checking that unmapped reads return zero.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LVL_LOW = 2'd0,
      SENSE_FALL    = 2'd1,
      SENSE_RISE    = 2'd2,
      SENSE_BOTH    = 2'd3
   } sense_e;

   localparam logic [7:0] OFS_NMI_STAT = 8'h00;
   localparam logic [7:0] OFS_NMI_CLR  = 8'h04;
   localparam logic [7:0] OFS_NMI_CFG  = 8'h08;
   localparam logic [7:0] OFS_IRQ_STAT = 8'h10;
   localparam logic [7:0] OFS_IRQ_CLR  = 8'h14;
   localparam logic [7:0] OFS_IRQ_CFG  = 8'h18;

   localparam int REG_W = 32;

   // non-maskable channel: one select bit mapped onto the shared edge codes
   function automatic sense_e nmi_cfg_to_sense(input logic sel);
      return sel ? SENSE_RISE : SENSE_FALL;
   endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int   WIDTH  = 17,
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pin_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= {WIDTH{IDLE}};
            else        stg_q[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= {WIDTH{IDLE}};
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/chan_detect.sv
module chan_detect
   import pin_irq_pkg::*;
#(
   parameter bit   ALLOW_LEVEL = 1'b1,
   parameter logic IDLE        = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   pin_s,
   input  sense_e sense,
   input  logic   clr,
   output logic   hit,
   output logic   flag
);

   logic prev_q;
   logic flag_q;
   logic flag_d;
   logic rise;
   logic fall;
   logic lvl_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= pin_s;
   end

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   always_comb begin
      unique case (sense)
         SENSE_FALL:    hit = fall;
         SENSE_RISE:    hit = rise;
         SENSE_BOTH:    hit = rise | fall;
         default:       hit = 1'b0;
      endcase
   end

   if (ALLOW_LEVEL) begin : g_level
      assign lvl_mode = (sense == SENSE_LVL_LOW);
   end else begin : g_edge_only
      assign lvl_mode = 1'b0;
   end

   // an edge in the clear cycle wins; level mode ignores clears
   always_comb begin
      if (lvl_mode) flag_d = ~pin_s;
      else          flag_d = hit | (flag_q & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag = flag_q;

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
   import pin_irq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      rdata,
   input  logic                  nmi_flag,
   input  logic [NUM_CH-1:0]     irq_flag,
   output logic                  nmi_cfg,
   output logic [2*NUM_CH-1:0]   irq_cfg,
   output logic                  nmi_clr,
   output logic [NUM_CH-1:0]     irq_clr
);

   localparam int CFG_W = 2 * NUM_CH;

   logic sel_nmi_stat, sel_nmi_clr, sel_nmi_cfg;
   logic sel_irq_stat, sel_irq_clr, sel_irq_cfg;
   logic unused_wdata;

   assign sel_nmi_stat = (addr == ADDR_W'(OFS_NMI_STAT));
   assign sel_nmi_clr  = (addr == ADDR_W'(OFS_NMI_CLR));
   assign sel_nmi_cfg  = (addr == ADDR_W'(OFS_NMI_CFG));
   assign sel_irq_stat = (addr == ADDR_W'(OFS_IRQ_STAT));
   assign sel_irq_clr  = (addr == ADDR_W'(OFS_IRQ_CLR));
   assign sel_irq_cfg  = (addr == ADDR_W'(OFS_IRQ_CFG));
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_cfg <= 1'b0;
         irq_cfg <= '0;
      end else if (wr_en) begin
         if (sel_nmi_cfg) nmi_cfg <= wdata[0];
         if (sel_irq_cfg) irq_cfg <= wdata[CFG_W-1:0];
      end
   end

   assign nmi_clr = wr_en & sel_nmi_clr & wdata[0];
   assign irq_clr = (wr_en & sel_irq_clr) ? wdata[NUM_CH-1:0] : '0;

   always_comb begin
      rdata = '0;
      if (sel_nmi_stat) rdata[0] = nmi_flag;
      if (sel_nmi_cfg)  rdata[0] = nmi_cfg;
      if (sel_irq_stat) rdata[NUM_CH-1:0] = irq_flag;
      if (sel_irq_cfg)  rdata[CFG_W-1:0] = irq_cfg;
   end

endmodule

// File: rtl/ext_pin_irq_detect.sv
module ext_pin_irq_detect
   import pin_irq_pkg::*;
#(
   parameter int   NUM_CH      = 16,
   parameter int   SYNC_STAGES = 2,
   parameter int   ADDR_W      = 8,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_pin,
   input  logic [NUM_CH-1:0] irq_pins,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              nmi_req,
   output logic [NUM_CH-1:0] irq_req
);

   localparam int NPIN = NUM_CH + 1;

   if (NUM_CH < 1 || 2 * NUM_CH > REG_W) begin : g_bad_ch
      $error("ext_pin_irq_detect: NUM_CH must be 1..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ext_pin_irq_detect: ADDR_W must be at least 8");
   end

   logic [NPIN-1:0]     pins_s;
   logic                nmi_cfg;
   logic [2*NUM_CH-1:0] irq_cfg_w;
   logic                nmi_clr;
   logic [NUM_CH-1:0]   irq_clr;
   logic                nmi_flag;
   logic                nmi_hit;
   logic [NUM_CH-1:0]   irq_flag;
   logic [NUM_CH-1:0]   irq_hit_w;
   sense_e              nmi_sense;

   pin_sync #(
      .WIDTH  (NPIN),
      .STAGES (SYNC_STAGES),
      .IDLE   (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({nmi_pin, irq_pins}),
      .dout  (pins_s)
   );

   pin_irq_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .nmi_flag (nmi_flag),
      .irq_flag (irq_flag),
      .nmi_cfg  (nmi_cfg),
      .irq_cfg  (irq_cfg_w),
      .nmi_clr  (nmi_clr),
      .irq_clr  (irq_clr)
   );

   assign nmi_sense = nmi_cfg_to_sense(nmi_cfg);

   chan_detect #(
      .ALLOW_LEVEL (1'b0),
      .IDLE        (PIN_IDLE)
   ) u_nmi (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pins_s[NUM_CH]),
      .sense (nmi_sense),
      .clr   (nmi_clr),
      .hit   (nmi_hit),
      .flag  (nmi_flag)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_detect #(
         .ALLOW_LEVEL (1'b1),
         .IDLE        (PIN_IDLE)
      ) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_s (pins_s[i]),
         .sense (sense_e'(irq_cfg_w[2*i +: 2])),
         .clr   (irq_clr[i]),
         .hit   (irq_hit_w[i]),
         .flag  (irq_flag[i])
      );
   end

   logic unused_nmi_hit;
   assign unused_nmi_hit = nmi_hit;

   assign nmi_req = nmi_flag;
   assign irq_req = irq_flag;

endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
   import pin_irq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int ADDR_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                nmi_pin,
   input logic [NUM_CH-1:0]   irq_pins,
   input logic                reg_wr_en,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic                nmi_req,
   input logic [NUM_CH-1:0]   irq_req,
   input logic [2*NUM_CH-1:0] irq_mode,
   input logic [NUM_CH-1:0]   irq_hit
);

   logic [2:0]        since_rst;
   logic [NUM_CH-1:0] lvl_m;
   logic [NUM_CH-1:0] edge_m;
   logic [NUM_CH-1:0] clr_v;
   logic              mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         lvl_m[i]  = (irq_mode[2*i +: 2] == 2'd0);
         edge_m[i] = (irq_mode[2*i +: 2] != 2'd0);
      end
   end

   assign clr_v  = (reg_wr_en && reg_addr == ADDR_W'(OFS_IRQ_CLR)) ? reg_wdata[NUM_CH-1:0] : '0;
   assign mapped = (reg_addr == ADDR_W'(OFS_NMI_STAT)) || (reg_addr == ADDR_W'(OFS_NMI_CFG)) ||
                   (reg_addr == ADDR_W'(OFS_IRQ_STAT)) || (reg_addr == ADDR_W'(OFS_IRQ_CFG));

   assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4) |->
      (((irq_req ^ ~$past(irq_pins, 3)) & lvl_m & $past(lvl_m, 1) & $past(lvl_m, 2)
        & $past(lvl_m, 3)) == '0));

   assert_irq_edge_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd6) |->
      ((irq_req & ~$past(irq_req) & $past(edge_m)
        & ~($past(irq_pins, 3) ^ $past(irq_pins, 4))) == '0));

   assert_nmi_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst >= 3'd6) && $rose(nmi_req)) |-> ($past(nmi_pin, 3) != $past(nmi_pin, 4)));

   assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v != '0) |=> ((irq_req & $past(clr_v) & $past(edge_m) & ~$past(irq_hit)) == '0));

   assert_hold_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd1) |->
      (($past(irq_req) & $past(edge_m) & ~$past(clr_v) & ~irq_req) == '0));

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd1) |-> ((~irq_req & $past(irq_hit)) == '0));

   assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (reg_rdata == 32'h0));

   assert_out_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({nmi_req, irq_req}));

endmodule

bind ext_pin_irq_detect pin_irq_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .nmi_pin   (nmi_pin),
   .irq_pins  (irq_pins),
   .reg_wr_en (reg_wr_en),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .nmi_req   (nmi_req),
   .irq_req   (irq_req),
   .irq_mode  (irq_cfg_w),
   .irq_hit   (irq_hit_w)
);

// File: tb/ext_pin_irq_detect_tb.sv
module ext_pin_irq_detect_tb;

   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_pin = 1'b1;
   logic [N-1:0]  irq_pins = '1;
   logic          reg_wr_en = 1'b0;
   logic [7:0]    reg_addr = 8'h0;
   logic [31:0]   reg_wdata = 32'h0;
   logic [31:0]   reg_rdata;
   logic          nmi_req;
   logic [N-1:0]  irq_req;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ext_pin_irq_detect u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_pin   (nmi_pin),
      .irq_pins  (irq_pins),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .nmi_req   (nmi_req),
      .irq_req   (irq_req)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      logic        e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 outputs in reset", {15'h0, nmi_req, irq_req}, 32'h0);
      rst_n = 1'b1;
      settle();
      chk("R1 outputs after reset", {15'h0, nmi_req, irq_req}, 32'h0);
      rd(8'h18, v); chk("R1 irq sense reset", v, 32'h0);
      rd(8'h08, v); chk("R1 nmi sense reset", v, 32'h0);
      rd(8'h10, v); chk("R1 irq status reset", v, 32'h0);
      rd(8'h00, v); chk("R1 nmi status reset", v, 32'h0);

      // R2: every word offset outside the four readable ones reads zero
      for (int a = 0; a < 256; a += 4) begin
         if (a != 8'h00 && a != 8'h08 && a != 8'h10 && a != 8'h18) begin
            rd(8'(a), v); chk("R2 unmapped read", v, 32'h0);
         end
      end

      // R3 readback of the sense register
      wr(8'h18, 32'h1B1B_E4E4);
      rd(8'h18, v); chk("R3 sense readback", v, 32'h1B1B_E4E4);
      wr(8'h18, 32'h0);
      settle();
      chk("R3 sense cleared", {16'h0, irq_req}, 32'h0);

      // R4/R5/R6/R9 sweep: every channel, every mode
      for (int n = 0; n < N; n++) begin
         for (int m = 0; m < 4; m++) begin
            wr(8'h18, 32'(m) << (2 * n));
            irq_pins[n] = 1'b0;
            settle();
            e = (m != 2);
            chk($sformatf("R4 R6 ch%0d mode%0d falling", n, m), {16'h0, irq_req}, 32'(e) << n);
            rd(8'h10, v);
            chk($sformatf("R9 ch%0d mode%0d status", n, m), v, 32'(e) << n);
            wr(8'h14, 32'h1 << n);
            settle();
            e = (m == 0);
            chk($sformatf("R5 R6 ch%0d mode%0d after clear", n, m), {16'h0, irq_req}, 32'(e) << n);
            irq_pins[n] = 1'b1;
            settle();
            e = (m == 2) || (m == 3);
            chk($sformatf("R4 R6 ch%0d mode%0d rising", n, m), {16'h0, irq_req}, 32'(e) << n);
            wr(8'h14, 32'h1 << n);
            settle();
            chk($sformatf("R5 ch%0d mode%0d final clear", n, m), {16'h0, irq_req}, 32'h0);
         end
      end

      // R5 writing zero bits leaves flags alone
      wr(8'h18, (32'h3 << 14) | (32'h3 << 16));
      irq_pins[7] = 1'b0; irq_pins[8] = 1'b0;
      settle();
      chk("R5 two flags set", {16'h0, irq_req}, 32'h0180);
      wr(8'h14, 32'h0);
      settle();
      chk("R5 zero write no effect", {16'h0, irq_req}, 32'h0180);
      wr(8'h14, 32'hFFFF_0100);
      settle();
      chk("R5 only bit 8 cleared", {16'h0, irq_req}, 32'h0080);
      irq_pins[7] = 1'b1; irq_pins[8] = 1'b1;
      settle();
      wr(8'h14, 32'hFFFF);
      settle();
      chk("R5 all cleared", {16'h0, irq_req}, 32'h0);

      // R7 edge and clear in the same cycle (channel 5, both edges)
      wr(8'h18, 32'h3 << 10);
      irq_pins[5] = 1'b0;
      settle();
      chk("R7 flag pre-set", {16'h0, irq_req}, 32'h0020);
      @(negedge clk); irq_pins[5] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); reg_wr_en = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h20;
      @(posedge clk);
      @(negedge clk); reg_wr_en = 1'b0; reg_wdata = 32'h0;
      chk("R7 set wins over clear", {16'h0, irq_req}, 32'h0020);
      wr(8'h14, 32'h20);
      chk("R7 later clear works", {16'h0, irq_req}, 32'h0);

      // R10 mode changes on a steady pin create no edge (channel 2)
      wr(8'h18, 32'h1 << 4);
      irq_pins[2] = 1'b0;
      settle();
      wr(8'h14, 32'h4);
      settle();
      chk("R10 falling cleared", {16'h0, irq_req}, 32'h0);
      wr(8'h18, 32'h2 << 4);
      settle();
      chk("R10 to rising no flag", {16'h0, irq_req}, 32'h0);
      wr(8'h18, 32'h3 << 4);
      settle();
      chk("R10 to both no flag", {16'h0, irq_req}, 32'h0);
      wr(8'h18, 32'h0);
      settle();
      chk("R6 to level low follows pin", {16'h0, irq_req}, 32'h0004);
      irq_pins[2] = 1'b1;
      settle();
      chk("R6 level released", {16'h0, irq_req}, 32'h0);

      // R8 non-maskable channel
      nmi_pin = 1'b0;
      settle();
      chk("R8 falling sets nmi", {31'h0, nmi_req}, 32'h1);
      rd(8'h00, v); chk("R8 nmi status", v, 32'h1);
      rd(8'h04, v); chk("R2 nmi clear reads zero", v, 32'h0);
      wr(8'h04, 32'h1);
      settle();
      chk("R8 nmi cleared", {31'h0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      settle();
      chk("R8 rising ignored in falling mode", {31'h0, nmi_req}, 32'h0);
      wr(8'h08, 32'h1);
      rd(8'h08, v); chk("R8 nmi sense readback", v, 32'h1);
      nmi_pin = 1'b0;
      settle();
      chk("R8 falling ignored in rising mode", {31'h0, nmi_req}, 32'h0);
      nmi_pin = 1'b1;
      settle();
      chk("R8 rising sets nmi", {31'h0, nmi_req}, 32'h1);
      wr(8'h04, 32'hFFFF_FFFE);
      settle();
      chk("R8 zero bit keeps nmi", {31'h0, nmi_req}, 32'h1);
      wr(8'h04, 32'h1);
      settle();
      chk("R8 nmi cleared again", {31'h0, nmi_req}, 32'h0);
      wr(8'h08, 32'hFFFF_FFFE);
      rd(8'h08, v); chk("R8 nmi sense only bit 0", v, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired R1 got=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule